// File: doc/BRIEF.md
# Octet-Synchronous HDLC-Style Frame Receiver

This block takes a byte-wide line stream, one octet per clock when a receive-enable is high, and turns it into packets. An optional self-synchronizing descrambler (polynomial x^43+1) sits at the front and runs continuously over every valid line octet, including the flags between frames. Behind it, a deframer locks onto the first flag, uses flags to delimit frames, undoes escape-based byte stuffing, and can verify and strip a 32-bit frame check sequence.

Packets leave on a byte-wide interface that marks each beat with valid, start, end and error flags. Two static control inputs choose whether descrambling and FCS checking are active. Because the end of a packet is only known once the closing flag arrives, the deframer always holds back the most recent frame octets. When checking is on it holds back the FCS octets plus one. When checking is off it holds back one octet.

Top module: `hdlc_octet_rx`

## Requirements
- R1: A line octet is consumed only in a cycle where `rx_valid` is high, and octets with `rx_valid` low have no effect. Every output beat appears exactly two clock cycles after the line octet that produces it.
- R2: After reset, all octets are discarded until the first flag octet 0x7E has been seen.
- R3: The flag octet 0x7E ends the current frame and starts the next one. Back-to-back flags with no data between them produce no output.
- R4: Inside a frame, the escape octet 0x7D is removed and the octet after it is delivered XORed with 0x20.
- R5: If an escape octet is followed directly by a flag, the frame is aborted. Its final beat carries `pkt_eop` and `pkt_err`.
- R6: With `cfg_descramble`=1, each line bit is processed least-significant bit first. Each line bit is XORed with the line bit received 43 bit positions earlier, and that history spans flags and frames. With `cfg_descramble`=0, octets pass through unchanged, but the history is still updated.
- R7: With FCS checking on, the last 4 octets of a frame are treated as the FCS and are not delivered. The CRC is CRC-32 (reflected, polynomial 0x04C11DB7, initial value all ones), run over all unstuffed frame octets including the FCS. If the result is not 0xDEBB20E3, `pkt_err` is set on the end beat. The FCS is sent as the inverted CRC, low byte first.
- R8: With FCS checking off, every unstuffed frame octet is delivered. `pkt_err` stays low unless the frame is aborted.
- R9: With FCS checking on, a frame of 1 to 4 octets produces a single beat with `pkt_sop`, `pkt_eop` and `pkt_err` all set and data 0x00.
- R10: `pkt_sop` marks the first beat of a packet and `pkt_eop` marks the last; a one-octet packet has both. Each beat is a single `pkt_valid` cycle. `pkt_err` appears only on an end beat. Sideband outputs and data are 0 when no beat is present.
- R11: `cfg_fcs_check` is sampled only while no frame octet is held. A change in the middle of a frame takes effect from the next frame.
- R12: During and right after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Line octet |
| rx_valid | input | 1 | Line octet qualifier |
| cfg_descramble | input | 1 | 1 enables x^43+1 descrambling |
| cfg_fcs_check | input | 1 | 1 enables FCS check and strip |
| pkt_data | output | 8 | Packet octet |
| pkt_valid | output | 1 | Beat present |
| pkt_sop | output | 1 | First beat of packet |
| pkt_eop | output | 1 | Last beat of packet |
| pkt_err | output | 1 | Packet bad (FCS, abort or runt), end beat only |

## Verification
Every result is due two cycles after the line octet that causes it: one cycle for the descrambler register and one for the output register. A data beat is triggered by the octet that pushes it out of the holdback, and an end beat is triggered by the closing flag. The reference model in the bench computes, for each driven octet, the beat that octet must cause. It delays that expectation through a two-entry pipe and compares all outputs on every falling edge. Expectations are therefore pinned to that exact cycle, and idle cycles are checked for silence.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int BYTE_W    = 8;
  localparam int SCR_LEN   = 43;
  localparam int FCS_BYTES = 4;
  localparam int CRC_W     = 32;

  localparam logic [BYTE_W-1:0] FLAG_OCTET = 8'h7E;
  localparam logic [BYTE_W-1:0] ESC_OCTET  = 8'h7D;
  localparam logic [BYTE_W-1:0] ESC_MASK   = 8'h20;

  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_INIT      = 32'hFFFF_FFFF;
  localparam logic [CRC_W-1:0] CRC_GOOD      = 32'hDEBB20E3;

  // Descramble one octet, LSB first; hist[0] is the newest line bit.
  function automatic logic [BYTE_W-1:0] descramble_byte(
      input logic [BYTE_W-1:0] line, input logic [SCR_LEN-1:0] hist);
    logic [SCR_LEN-1:0] h;
    logic [BYTE_W-1:0]  o;
    h = hist;
    for (int i = 0; i < BYTE_W; i++) begin
      o[i] = line[i] ^ h[SCR_LEN-1];
      h    = {h[SCR_LEN-2:0], line[i]};
    end
    return o;
  endfunction

  function automatic logic [SCR_LEN-1:0] hist_advance(
      input logic [BYTE_W-1:0] line, input logic [SCR_LEN-1:0] hist);
    logic [SCR_LEN-1:0] h;
    h = hist;
    for (int i = 0; i < BYTE_W; i++) h = {h[SCR_LEN-2:0], line[i]};
    return h;
  endfunction

  function automatic logic [CRC_W-1:0] crc32_step(
      input logic [CRC_W-1:0] crc, input logic [BYTE_W-1:0] b);
    logic [CRC_W-1:0] c;
    c = crc;
    for (int i = 0; i < BYTE_W; i++) begin
      if (c[0] ^ b[i]) c = (c >> 1) ^ CRC_POLY_REFL;
      else             c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/hdlc_rx_descrambler.sv
module hdlc_rx_descrambler
  import hdlc_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] line_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] byte_o
);
  logic [SCR_LEN-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q  <= '0;
      valid_o <= 1'b0;
      byte_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        hist_q <= hist_advance(line_i, hist_q);
        byte_o <= en_i ? descramble_byte(line_i, hist_q) : line_i;
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_fcs32.sv
module hdlc_rx_fcs32
  import hdlc_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              upd_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              ok_o
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     crc_q <= CRC_INIT;
    else if (clr_i) crc_q <= CRC_INIT;
    else if (upd_i) crc_q <= crc32_step(crc_q, byte_i);
  end

  assign ok_o = (crc_q == CRC_GOOD);
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fcs_cfg_i,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              crc_ok_i,
  output logic              crc_clr_o,
  output logic              crc_upd_o,
  output logic [BYTE_W-1:0] crc_byte_o,
  output logic              ev_close_o,
  output logic [BYTE_W-1:0] pkt_data,
  output logic              pkt_valid,
  output logic              pkt_sop,
  output logic              pkt_eop,
  output logic              pkt_err
);
  localparam int HOLD  = FCS_BYTES + 1;
  localparam int CNT_W = $clog2(HOLD + 1);

  logic              synced_q, esc_q, started_q, fcs_on_q;
  logic [CNT_W-1:0]  cnt_q, k_sel;
  logic [BYTE_W-1:0] hold_q [HOLD];

  // Named events
  logic              ev_flag, ev_esc, ev_data, ev_push, ev_close, full;
  logic [BYTE_W-1:0] data_val;

  assign ev_flag  = valid_i && (byte_i == FLAG_OCTET);
  assign ev_esc   = valid_i && synced_q && !esc_q && (byte_i == ESC_OCTET);
  assign ev_data  = valid_i && synced_q && !ev_flag && !ev_esc;
  assign data_val = esc_q ? (byte_i ^ ESC_MASK) : byte_i;
  assign k_sel    = fcs_on_q ? CNT_W'(FCS_BYTES) : '0;
  assign full     = (cnt_q == k_sel + CNT_W'(1));
  assign ev_push  = ev_data && full;
  assign ev_close = ev_flag && synced_q && (cnt_q != '0);

  assign crc_clr_o  = ev_flag;
  assign crc_upd_o  = ev_data;
  assign crc_byte_o = data_val;
  assign ev_close_o = ev_close;

  logic              nx_valid, nx_sop, nx_eop, nx_err;
  logic [BYTE_W-1:0] nx_data;

  always_comb begin
    nx_valid = 1'b0;
    nx_sop   = 1'b0;
    nx_eop   = 1'b0;
    nx_err   = 1'b0;
    nx_data  = '0;
    if (ev_close) begin
      nx_valid = 1'b1;
      nx_eop   = 1'b1;
      if (full) begin
        nx_data = hold_q[k_sel];
        nx_sop  = !started_q;
        nx_err  = esc_q || (fcs_on_q && !crc_ok_i);
      end else begin
        nx_sop = 1'b1;
        nx_err = 1'b1;
      end
    end else if (ev_push) begin
      nx_valid = 1'b1;
      nx_sop   = !started_q;
      nx_data  = hold_q[k_sel];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      synced_q  <= 1'b0;
      esc_q     <= 1'b0;
      started_q <= 1'b0;
      fcs_on_q  <= 1'b0;
      cnt_q     <= '0;
      pkt_valid <= 1'b0;
      pkt_sop   <= 1'b0;
      pkt_eop   <= 1'b0;
      pkt_err   <= 1'b0;
      pkt_data  <= '0;
    end else begin
      pkt_valid <= nx_valid;
      pkt_sop   <= nx_sop;
      pkt_eop   <= nx_eop;
      pkt_err   <= nx_err;
      pkt_data  <= nx_data;
      if (cnt_q == '0) fcs_on_q <= fcs_cfg_i;
      if (ev_flag) begin
        synced_q  <= 1'b1;
        esc_q     <= 1'b0;
        started_q <= 1'b0;
        cnt_q     <= '0;
      end else if (ev_esc) begin
        esc_q <= 1'b1;
      end else if (ev_data) begin
        esc_q <= 1'b0;
        if (full) started_q <= 1'b1;
        else      cnt_q     <= cnt_q + CNT_W'(1);
      end
    end
  end

  // Holdback shift register: stage 0 is the newest unstuffed octet.
  always_ff @(posedge clk) begin
    if (!rst_n)       hold_q[0] <= '0;
    else if (ev_data) hold_q[0] <= data_val;
  end

  for (genvar g = 1; g < HOLD; g++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rst_n)       hold_q[g] <= '0;
      else if (ev_data) hold_q[g] <= hold_q[g-1];
    end
  end
endmodule

// File: rtl/hdlc_octet_rx.sv
module hdlc_octet_rx
  import hdlc_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_valid,
  input  logic              cfg_descramble,
  input  logic              cfg_fcs_check,
  output logic [BYTE_W-1:0] pkt_data,
  output logic              pkt_valid,
  output logic              pkt_sop,
  output logic              pkt_eop,
  output logic              pkt_err
);
  logic              d1_valid;
  logic [BYTE_W-1:0] d1_byte;
  logic              crc_clr, crc_upd, crc_ok, ev_close;
  logic [BYTE_W-1:0] crc_byte;

  hdlc_rx_descrambler u_descr (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (cfg_descramble),
    .valid_i (rx_valid),
    .line_i  (rx_byte),
    .valid_o (d1_valid),
    .byte_o  (d1_byte)
  );

  hdlc_rx_fcs32 u_fcs (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (crc_clr),
    .upd_i  (crc_upd),
    .byte_i (crc_byte),
    .ok_o   (crc_ok)
  );

  hdlc_rx_deframer u_defr (
    .clk        (clk),
    .rst_n      (rst_n),
    .fcs_cfg_i  (cfg_fcs_check),
    .valid_i    (d1_valid),
    .byte_i     (d1_byte),
    .crc_ok_i   (crc_ok),
    .crc_clr_o  (crc_clr),
    .crc_upd_o  (crc_upd),
    .crc_byte_o (crc_byte),
    .ev_close_o (ev_close),
    .pkt_data   (pkt_data),
    .pkt_valid  (pkt_valid),
    .pkt_sop    (pkt_sop),
    .pkt_eop    (pkt_eop),
    .pkt_err    (pkt_err)
  );
endmodule

// File: rtl/hdlc_rx_chk.sv
module hdlc_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic [7:0] rx_byte,
  input logic       cfg_descramble,
  input logic       d1_valid,
  input logic [7:0] d1_byte,
  input logic       ev_close,
  input logic       pkt_valid,
  input logic       pkt_sop,
  input logic       pkt_eop,
  input logic       pkt_err
);
  logic open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) open_q <= 1'b0;
    else if (pkt_valid && pkt_eop) open_q <= 1'b0;
    else if (pkt_valid && pkt_sop) open_q <= 1'b1;
  end

  // R1: a beat traces back to a valid line octet two cycles earlier
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> $past(rx_valid, 2));

  // R6: bypass passes the line octet through unchanged
  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (d1_valid && !$past(cfg_descramble)) |-> (d1_byte == $past(rx_byte)));

  // R3: a frame close yields an end beat next cycle
  p_close_eop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_close |=> (pkt_valid && pkt_eop));

  // R10: error only on an end beat
  p_err_on_eop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_err) |-> pkt_eop);

  // R10: no sideband without a beat
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |-> !(pkt_sop || pkt_eop || pkt_err));

  // R10: start only when no packet is open
  p_sop_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_sop) |-> !open_q);

  // R10: continuation only inside an open packet
  p_mid_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_sop) |-> open_q);
endmodule

bind hdlc_octet_rx hdlc_rx_chk chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .rx_valid       (rx_valid),
  .rx_byte        (rx_byte),
  .cfg_descramble (cfg_descramble),
  .d1_valid       (d1_valid),
  .d1_byte        (d1_byte),
  .ev_close       (ev_close),
  .pkt_valid      (pkt_valid),
  .pkt_sop        (pkt_sop),
  .pkt_eop        (pkt_eop),
  .pkt_err        (pkt_err)
);

// File: tb/hdlc_octet_rx_tb_top.sv
module hdlc_octet_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] rx_byte;
  logic       rx_valid;
  logic       cfg_d, cfg_f;
  logic [7:0] pkt_data;
  logic       pkt_valid, pkt_sop, pkt_eop, pkt_err;

  always #2 clk = ~clk;

  hdlc_octet_rx dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_byte        (rx_byte),
    .rx_valid       (rx_valid),
    .cfg_descramble (cfg_d),
    .cfg_fcs_check  (cfg_f),
    .pkt_data       (pkt_data),
    .pkt_valid      (pkt_valid),
    .pkt_sop        (pkt_sop),
    .pkt_eop        (pkt_eop),
    .pkt_err        (pkt_err)
  );

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  // Reference model state
  bit         m_sync = 0;
  bit         m_esc  = 0;
  int         m_k    = 0;
  logic [7:0] bq[$];
  bit         line_bits[$];

  logic [11:0] expA = '0, expB = '0;
  string       tagA = "R12", tagB = "R12", cur_tag = "R12";

  function automatic logic [31:0] crc_of(input logic [7:0] q[$], input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int j = 0; j < n; j++) begin
      c ^= {24'h0, q[j]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic bit fcs_good();
    int n = bq.size();
    return {bq[n-1], bq[n-2], bq[n-3], bq[n-4]} == crc_of(bq, n - 4);
  endfunction

  task automatic model(input logic v, input logic [7:0] b, output logic [11:0] e);
    int n, idx;
    logic [7:0] d;
    e = '0;
    if (!v) return;
    if (b == 8'h7E) begin
      n = bq.size();
      if (m_sync && n > 0) begin
        if (n > m_k) begin
          idx = n - m_k - 1;
          e = {1'b1, (idx == 0), 1'b1, (m_esc || (m_k > 0 && !fcs_good())), bq[idx]};
        end else e = {4'b1111, 8'h00};
      end
      m_sync = 1; m_esc = 0; bq.delete();
    end else if (m_sync) begin
      if (!m_esc && b == 8'h7D) m_esc = 1;
      else begin
        d = m_esc ? (b ^ 8'h20) : b;
        m_esc = 0;
        if (bq.size() == 0) m_k = cfg_f ? 4 : 0;
        bq.push_back(d);
        if (bq.size() > m_k + 1) begin
          idx = bq.size() - m_k - 2;
          e = {1'b1, (idx == 0), 2'b00, bq[idx]};
        end
      end
    end
  endtask

  task automatic line_byte(input logic [7:0] p, output logic [7:0] o);
    bit s;
    for (int i = 0; i < 8; i++) begin
      s = cfg_d ? (p[i] ^ line_bits[line_bits.size() - 43]) : p[i];
      o[i] = s;
      line_bits.push_back(s);
      if (line_bits.size() > 60) void'(line_bits.pop_front());
    end
  endtask

  task automatic tick(input logic v, input logic [7:0] p);
    logic [11:0] act, e;
    logic [7:0]  o;
    act = {pkt_valid, pkt_sop, pkt_eop, pkt_err, pkt_data};
    total++;
    if (act !== expA) begin
      bad++;
      $display("FAIL %s: got v/s/e/err=%b data=%02h, expected v/s/e/err=%b data=%02h",
               tagA, act[11:8], act[7:0], expA[11:8], expA[7:0]);
    end
    expA = expB; tagA = tagB;
    model(v, p, e);
    expB = e; tagB = cur_tag;
    if (v) line_byte(p, o);
    else   o = p;
    rx_byte  = o;
    rx_valid = v;
    @(negedge clk);
  endtask

  task automatic send_body(input logic [7:0] body[$]);
    foreach (body[i]) begin
      if (body[i] == 8'h7E || body[i] == 8'h7D) begin
        tick(1, 8'h7D);
        tick(1, body[i] ^ 8'h20);
      end else tick(1, body[i]);
    end
    tick(1, 8'h7E);
  endtask

  task automatic send_fcs_frame(input logic [7:0] pay[$], input bit corrupt);
    logic [7:0]  f[$];
    logic [31:0] c;
    f = pay;
    c = crc_of(pay, pay.size());
    if (corrupt) c ^= 32'h0000_0100;
    f.push_back(c[7:0]);  f.push_back(c[15:8]);
    f.push_back(c[23:16]); f.push_back(c[31:24]);
    send_body(f);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 8'h00);
  endtask

  initial begin
    for (int i = 0; i < 43; i++) line_bits.push_back(1'b0);
    rst_n = 0; rx_byte = 0; rx_valid = 0; cfg_d = 0; cfg_f = 0;
    repeat (4) @(negedge clk);
    // R12: reset state
    total++;
    if ({pkt_valid, pkt_sop, pkt_eop, pkt_err, pkt_data} !== 12'h000) begin
      bad++;
      $display("FAIL R12: got %03h expected 000", {pkt_valid, pkt_sop, pkt_eop, pkt_err, pkt_data});
    end
    rst_n = 1;
    @(negedge clk);

    cur_tag = "R2";  tick(1, 8'h11); tick(1, 8'h7D); tick(1, 8'h22); idle(2);
    cur_tag = "R3";  tick(1, 8'h7E); tick(1, 8'h7E); tick(1, 8'h7E); idle(3);
    cur_tag = "R4 R8"; send_body('{8'hA1, 8'h7E, 8'h7D, 8'h55});
    cur_tag = "R10"; send_body('{8'h3C}); idle(2);
    cur_tag = "R5";  tick(1, 8'h01); tick(1, 8'h02); tick(1, 8'h7D); tick(1, 8'h7E);
    tick(1, 8'h09); tick(1, 8'h7D); tick(1, 8'h7E); idle(2);

    cfg_f = 1; idle(3);
    cur_tag = "R7";  send_fcs_frame('{8'h10, 8'h20, 8'h7E, 8'h30, 8'h40, 8'h50}, 0);
    send_fcs_frame('{8'hC3}, 0);
    send_fcs_frame('{8'h10, 8'h20, 8'h7E, 8'h30}, 1);
    cur_tag = "R9";  send_body('{8'h01, 8'h02, 8'h03});
    send_body('{8'h09, 8'h08, 8'h07, 8'h06});
    idle(2);

    cfg_d = 1; idle(2);
    cur_tag = "R6";  tick(1, 8'h7E); tick(1, 8'h7E);
    send_fcs_frame('{8'hDE, 8'hAD, 8'h7D, 8'hBE, 8'hEF, 8'h00, 8'hFF}, 0);
    cur_tag = "R1";  tick(1, 8'h44); tick(0, 8'h7E); tick(1, 8'h45); tick(0, 8'h7D);
    tick(1, 8'h46); tick(0, 8'hAA); tick(1, 8'h47); tick(1, 8'h48); tick(0, 8'h7E);
    tick(1, 8'h49); tick(1, 8'h7E); idle(2);

    cfg_d = 0; cfg_f = 0; idle(3);
    cur_tag = "R11"; tick(1, 8'h61); tick(1, 8'h62); tick(1, 8'h63);
    cfg_f = 1;
    tick(1, 8'h64); tick(1, 8'h65); tick(1, 8'h66); tick(1, 8'h7E); idle(3);
    send_fcs_frame('{8'h71, 8'h72}, 0);
    idle(4);

    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog: got no end, expected end of stimulus");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule